// File: doc/BRIEF.md
# Oversampled Line Edge-Phase Monitor

This block watches a serial line while a link is starting up. The line is sampled eight times per bit period, so each bit period holds eight sample phases. The block keeps one sticky flag per phase. A flag is set when the line value at a sample differs from the value at the sample before it. The resulting pattern is a fingerprint of where transitions fall inside the bit period. A clean line sets only a few neighbouring flags. A noisy line sets many of them. When every flag is set, the interference is judged too high for a link to form.

Capture runs only while the start-up flag is high. When start-up ends, the pattern freezes and a done flag rises. The pattern then stays unchanged until a forced protocol reset clears it and opens a new capture. The pattern is read-only. No input other than the forced reset can alter it once it is frozen.

Top module: `linephase_mon`

## Requirements
- R1: After reset, `pattern_o` is all zeros and `done_o` and `fault_o` are low.
- R2: The first accepted sample after a capture opens only loads the previous-sample register. It never sets a pattern bit, even when the line differs from its reset value of 0.
- R3: The first accepted sample of a capture is phase 0. Each accepted strobe advances the phase by one, and the phase wraps from 7 to 0. An edge seen at phase k sets `pattern_o` bit k, one cycle after the strobe.
- R4: Pattern bits are sticky: a set bit stays set until reset or a forced reset.
- R5: A line change that does not coincide with `smp_en_i` is not sampled and leaves the pattern unchanged.
- R6: A sample is accepted only while `startup_i` is high and the capture is not yet done. After start-up ends, the pattern does not change under any line or strobe activity.
- R7: `done_o` rises in the cycle after `startup_i` falls during a capture. It stays high until a forced reset, even if `startup_i` rises again.
- R8: `force_rst_i` clears the pattern and `done_o` in the following cycle and restarts the phase at 0. It takes priority over an edge in the same cycle.
- R9: `fault_o` is high exactly when all eight pattern bits are set. It is asserted in the same cycle as the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_en_i | input | 1 | Sample strobe at eight times the bit rate |
| line_i | input | 1 | Raw line value |
| startup_i | input | 1 | High while the link start-up phase runs |
| force_rst_i | input | 1 | Forced protocol reset; clears and re-arms the capture |
| pattern_o | output | PHASES (8) | Per-phase edge pattern, bit k for phase k |
| done_o | output | 1 | Capture finished; pattern frozen |
| fault_o | output | 1 | All phases saw an edge |

## Verification
Each pattern bit appears one cycle after the strobe that carries its edge. `done_o` appears one cycle after `startup_i` falls. The cleared state appears one cycle after `force_rst_i`. `fault_o` follows the pattern with no added delay.

The bench drives every input on the falling clock edge and checks outputs on the next falling edge. Each result is therefore read half a period after the register that produces it has updated. The one exception is the check that `done_o` is still low. It is made on the same falling edge where `startup_i` is dropped, before any rising edge can act on it.

// File: rtl/linephase_pkg.sv
package linephase_pkg;

   typedef enum logic [1:0] {
      LPM_IDLE    = 2'd0,
      LPM_CAPTURE = 2'd1,
      LPM_FROZEN  = 2'd2
   } lpm_state_e;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import linephase_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic startup_i,
   input  logic force_rst_i,
   output logic cap_en_o,
   output logic done_o
);

   lpm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LPM_IDLE:    if (startup_i)  state_d = LPM_CAPTURE;
         LPM_CAPTURE: if (!startup_i) state_d = LPM_FROZEN;
         LPM_FROZEN:  state_d = LPM_FROZEN;
         default:     state_d = LPM_IDLE;
      endcase
      if (force_rst_i) state_d = LPM_IDLE;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= LPM_IDLE;
      else         state_q <= state_d;
   end

   assign cap_en_o = startup_i && (state_q != LPM_FROZEN) && !force_rst_i;
   assign done_o   = (state_q == LPM_FROZEN);

endmodule

// File: rtl/lpm_phase_ctr.sv
module lpm_phase_ctr #(
   parameter int PHASES = 8,
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          step_i,
   output logic [PW-1:0] phase_o
);

   logic [PW-1:0] phase_q, phase_nx;

   generate
      if ((1 << PW) == PHASES) begin : g_wrap_free
         assign phase_nx = phase_q + 1'b1;
      end else begin : g_wrap_cmp
         assign phase_nx = (phase_q == PW'(PHASES - 1)) ? '0 : phase_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) phase_q <= '0;
      else if (step_i)      phase_q <= phase_nx;
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/lpm_edge_det.sv
module lpm_edge_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic step_i,
   input  logic line_i,
   output logic edge_o
);

   logic prev_q;
   logic primed_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
      end else if (step_i) begin
         prev_q   <= line_i;
         primed_q <= 1'b1;
      end
   end

   assign edge_o = step_i && primed_q && (line_i != prev_q);

endmodule

// File: rtl/lpm_hist_reg.sv
module lpm_hist_reg #(
   parameter int PHASES = 8,
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              edge_i,
   input  logic [PW-1:0]     phase_i,
   output logic [PHASES-1:0] pattern_o
);

   generate
      for (genvar i = 0; i < PHASES; i++) begin : g_cell
         logic hit_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni || clr_i)                  hit_q <= 1'b0;
            else if (edge_i && phase_i == PW'(i)) hit_q <= 1'b1;
         end
         assign pattern_o[i] = hit_q;
      end
   endgenerate

endmodule

// File: rtl/linephase_mon.sv
module linephase_mon #(
   parameter int PHASES = 8,
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              smp_en_i,
   input  logic              line_i,
   input  logic              startup_i,
   input  logic              force_rst_i,
   output logic [PHASES-1:0] pattern_o,
   output logic              done_o,
   output logic              fault_o
);

   generate
      if (PHASES < 2) begin : g_bad_phases
         $error("linephase_mon: PHASES must be at least 2");
      end
   endgenerate

   logic          cap_en;
   logic          step;
   logic          edge_hit;
   logic [PW-1:0] phase;

   lpm_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .startup_i   (startup_i),
      .force_rst_i (force_rst_i),
      .cap_en_o    (cap_en),
      .done_o      (done_o)
   );

   assign step = smp_en_i && cap_en;

   lpm_phase_ctr #(.PHASES(PHASES)) u_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (force_rst_i),
      .step_i  (step),
      .phase_o (phase)
   );

   lpm_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (force_rst_i),
      .step_i (step),
      .line_i (line_i),
      .edge_o (edge_hit)
   );

   lpm_hist_reg #(.PHASES(PHASES)) u_hist (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (force_rst_i),
      .edge_i    (edge_hit),
      .phase_i   (phase),
      .pattern_o (pattern_o)
   );

   assign fault_o = &pattern_o;

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
   parameter int PHASES = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              smp_en_i,
   input logic              force_rst_i,
   input logic [PHASES-1:0] pattern_o,
   input logic              done_o,
   input logic              fault_o
);

   p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !force_rst_i |=> ((pattern_o & $past(pattern_o)) == $past(pattern_o)));

   p_one_bit_per_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !force_rst_i |=> ($countones(pattern_o ^ $past(pattern_o)) <= 1));

   p_no_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!smp_en_i && !force_rst_i) |=> $stable(pattern_o));

   p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !force_rst_i) |=> $stable(pattern_o));

   p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !force_rst_i) |=> done_o);

   p_force_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_rst_i |=> (pattern_o == '0 && !done_o));

   p_fault_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o && !force_rst_i) |=> fault_o);

endmodule

bind linephase_mon lpm_checker #(.PHASES(PHASES)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .smp_en_i    (smp_en_i),
   .force_rst_i (force_rst_i),
   .pattern_o   (pattern_o),
   .done_o      (done_o),
   .fault_o     (fault_o)
);

// File: tb/tb_linephase_mon.sv
module tb_linephase_mon;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       smp_en;
   logic       line;
   logic       startup;
   logic       force_rst;
   logic [7:0] pattern;
   logic       done;
   logic       fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   linephase_mon dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .smp_en_i    (smp_en),
      .line_i      (line),
      .startup_i   (startup),
      .force_rst_i (force_rst),
      .pattern_o   (pattern),
      .done_o      (done),
      .fault_o     (fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic v);
      smp_en = 1'b1;
      line   = v;
      @(negedge clk);
      smp_en = 1'b0;
   endtask

   task automatic pulse_force();
      force_rst = 1'b1;
      @(negedge clk);
      force_rst = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 pattern", pattern, 0);
      chk("R1 done", done, 0);
      chk("R1 fault", fault, 0);
   endtask

   task automatic t_first_sample();
      startup = 1'b1;
      strobe(1'b1);
      chk("R2 first sample loads only", pattern, 8'h00);
   endtask

   task automatic t_phase_wrap();
      strobe(1'b1);
      strobe(1'b0);
      chk("R3 edge at phase 2", pattern, 8'h04);
      for (int i = 3; i < 8; i++) strobe(1'b0);
      strobe(1'b1);
      chk("R3 wrap to phase 0", pattern, 8'h05);
   endtask

   task automatic t_no_strobe();
      for (int i = 0; i < 4; i++) begin
         line = ~line;
         @(negedge clk);
      end
      chk("R5 line change without strobe", pattern, 8'h05);
   endtask

   task automatic t_sticky();
      strobe(1'b1);
      strobe(1'b0);
      chk("R4 bits stay set", pattern, 8'h05);
   endtask

   task automatic t_freeze();
      startup = 1'b0;
      chk("R7 done not yet", done, 0);
      @(negedge clk);
      chk("R7 done one cycle later", done, 1);
      strobe(1'b1);
      strobe(1'b0);
      chk("R6 pattern frozen", pattern, 8'h05);
      startup = 1'b1;
      strobe(1'b1);
      strobe(1'b0);
      chk("R6 frozen after restart of startup", pattern, 8'h05);
      chk("R7 done held", done, 1);
   endtask

   task automatic t_force();
      pulse_force();
      chk("R8 clear pattern", pattern, 8'h00);
      chk("R8 clear done", done, 0);
      strobe(1'b0);
      strobe(1'b1);
      chk("R3 new capture phase 1", pattern, 8'h02);
      force_rst = 1'b1;
      smp_en    = 1'b1;
      line      = 1'b0;
      @(negedge clk);
      force_rst = 1'b0;
      smp_en    = 1'b0;
      chk("R8 priority over edge", pattern, 8'h00);
      strobe(1'b1);
      chk("R2 first sample after force", pattern, 8'h00);
      strobe(1'b0);
      chk("R8 phase restarted", pattern, 8'h02);
   endtask

   task automatic t_fault();
      for (int i = 0; i < 6; i++) strobe((i % 2 == 0) ? 1'b1 : 1'b0);
      chk("R9 pattern seven bits", pattern, 8'hFE);
      chk("R9 no fault yet", fault, 0);
      strobe(1'b1);
      chk("R9 all bits", pattern, 8'hFF);
      chk("R9 fault raised", fault, 1);
      pulse_force();
      chk("R9 fault cleared", fault, 0);
   endtask

   initial begin
      rst_n = 1'b0; smp_en = 1'b0; line = 1'b0; startup = 1'b0; force_rst = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_sample();
      t_phase_wrap();
      t_no_strobe();
      t_sticky();
      t_freeze();
      t_force();
      t_fault();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule